// File: doc/BRIEF.md
# Packed String Compare Engine

The engine compares two 128-bit packed strings element by element. Each string holds sixteen byte characters or eight 16-bit word characters. Characters are read as signed or unsigned. Each string's active part is set in one of two ways. An explicit length input can fix it. The length is taken as a magnitude and clipped to the element count. A terminating zero element can also end the string. Every element pair gets one true/false outcome under an element-wise equality rule. Positions past the end of both strings count as matching.

The outcome vector is reported in one of two formats. In index format it is the position of its lowest true element. In mask format each element lane is filled with copies of its outcome bit. Four status flags come with either format. Results are registered and appear one cycle after the input strobe.

A small controller has two named states. ST_IDLE means no result is being presented. ST_DONE means a fresh result is on the outputs for this cycle. The transition ST_IDLE->ST_DONE and the transition ST_DONE->ST_DONE are both taken when `in_valid` is high. The transition ST_DONE->ST_IDLE and the transition ST_IDLE->ST_IDLE are both taken when `in_valid` is low.

Top module: `pstr_cmp_engine`

## Requirements
- R1: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high. The result outputs change only on such a load and hold their values otherwise.
- R2: When `len_implicit`=0, each string's length is the magnitude of its 32-bit two's-complement length input, clipped to the element count. In this mode a zero element is ordinary data.
- R3: A negative explicit length acts like its absolute value. For example, -4 gives 4 valid elements and -32 is clipped to the element count.
- R4: When `len_implicit`=1, each string ends at its lowest-numbered zero element, and that element and all above it are invalid. The length inputs have no effect in this mode.
- R5: When `word_mode`=0 there are 16 elements, and element i occupies bits [8i+7:8i]. When `word_mode`=1 there are 8 elements, and element i occupies bits [16i+15:16i].
- R6: An element pair is true when both elements are valid and equal, or when both are invalid. A pair with exactly one valid element is false.
- R7: When `mask_format`=0, `idx_out` is the lowest position with a true outcome, or the element count (16 or 8) if none is true. In this format `mask_out` is zero.
- R8: When `mask_format`=1, each true element sets all bits of its lane in `mask_out`, with the lanes placed as in R5. In this format `idx_out` is zero.
- R9: `flag_any` is set if any outcome is true. `flag_a_end` and `flag_b_end` are set when the valid length of A or of B is below the element count. `flag_bit0` equals the outcome of element 0.
- R10: `signed_mode` does not change any output.
- R11: After reset, `out_valid`, `idx_out`, `mask_out` and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Compare request strobe |
| str_a | input | 128 | Packed string A |
| str_b | input | 128 | Packed string B |
| len_a | input | 32 | Explicit length of A, two's complement |
| len_b | input | 32 | Explicit length of B, two's complement |
| len_implicit | input | 1 | 1: length set by zero terminator, 0: by length inputs |
| word_mode | input | 1 | 1: 16-bit elements, 0: byte elements |
| signed_mode | input | 1 | Signed character interpretation |
| mask_format | input | 1 | 1: mask result, 0: index result |
| out_valid | output | 1 | Result strobe |
| idx_out | output | 32 | Index result |
| mask_out | output | 128 | Mask result |
| flag_any | output | 1 | Some outcome true |
| flag_a_end | output | 1 | A ends inside the register |
| flag_b_end | output | 1 | B ends inside the register |
| flag_bit0 | output | 1 | Outcome of element 0 |

## Verification
Length limiting and the equality test act on the same element in the same cycle. The hard case is a string end that falls on an element where the two strings also differ or hold a zero. The bench provokes this in two ways. Directed vectors place mismatches, zero elements and length cut points on the same positions. Random vectors copy B from A, then perturb single elements and inject zeros at chosen positions. Every vector is judged against a bench reference model. The model computes the outcome vector, the index, the lane mask and the flags from the requirements alone.

// File: rtl/pstr_pkg.sv
package pstr_pkg;
    localparam int PSTR_W  = 128;
    localparam int PSTR_LW = 32;
    localparam int PSTR_IW = 32;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } pstr_state_e;
endpackage

// File: rtl/pstr_len_unit.sv
module pstr_len_unit #(
    parameter int W  = pstr_pkg::PSTR_W,
    parameter int LW = pstr_pkg::PSTR_LW
) (
    input  logic [W-1:0]    str,
    input  logic [LW-1:0]   len,
    input  logic            implicit_len,
    input  logic            word_mode,
    output logic [W/8-1:0]  valid,
    output logic            ends_early
);
    localparam int NB = W / 8;
    localparam int CW = $clog2(NB + 1);

    logic [NB-1:0] nul;
    logic [LW-1:0] mag;
    logic [CW-1:0] cnt, sat_len, nul_len, eff_len;

    for (genvar i = 0; i < NB; i++) begin : g_nul
        if (i < NB / 2) begin : g_lo
            assign nul[i] = word_mode ? (str[16*i +: 16] == 16'h0) : (str[8*i +: 8] == 8'h0);
        end else begin : g_hi
            assign nul[i] = ~word_mode & (str[8*i +: 8] == 8'h0);
        end
    end

    always_comb begin
        cnt     = word_mode ? CW'(NB / 2) : CW'(NB);
        mag     = len[LW-1] ? (~len + 1'b1) : len;
        sat_len = (mag >= LW'(cnt)) ? cnt : mag[CW-1:0];
        nul_len = cnt;
        for (int i = NB - 1; i >= 0; i--) begin
            if (nul[i] && (CW'(i) < cnt)) nul_len = CW'(i);
        end
        eff_len    = implicit_len ? nul_len : sat_len;
        ends_early = eff_len < cnt;
        for (int i = 0; i < NB; i++) begin
            valid[i] = CW'(i) < eff_len;
        end
    end
endmodule

// File: rtl/pstr_cmp_core.sv
module pstr_cmp_core #(
    parameter int W = pstr_pkg::PSTR_W
) (
    input  logic [W-1:0]    str_a,
    input  logic [W-1:0]    str_b,
    input  logic [W/8-1:0]  valid_a,
    input  logic [W/8-1:0]  valid_b,
    input  logic            word_mode,
    input  logic            signed_mode,
    output logic [W/8-1:0]  res
);
    localparam int NB = W / 8;

    logic [NB-1:0] eq;

    for (genvar i = 0; i < NB; i++) begin : g_eq
        logic [8:0] ea_b, eb_b;
        assign ea_b = {signed_mode & str_a[8*i+7], str_a[8*i +: 8]};
        assign eb_b = {signed_mode & str_b[8*i+7], str_b[8*i +: 8]};
        if (i < NB / 2) begin : g_lo
            logic [16:0] ea_w, eb_w;
            assign ea_w  = {signed_mode & str_a[16*i+15], str_a[16*i +: 16]};
            assign eb_w  = {signed_mode & str_b[16*i+15], str_b[16*i +: 16]};
            assign eq[i] = word_mode ? (ea_w == eb_w) : (ea_b == eb_b);
        end else begin : g_hi
            assign eq[i] = ~word_mode & (ea_b == eb_b);
        end
        assign res[i] = ((valid_a[i] & valid_b[i] & eq[i]) | (~valid_a[i] & ~valid_b[i]))
                        & ~(word_mode & (i >= NB / 2));
    end
endmodule

// File: rtl/pstr_result_fmt.sv
module pstr_result_fmt #(
    parameter int W  = pstr_pkg::PSTR_W,
    parameter int IW = pstr_pkg::PSTR_IW
) (
    input  logic [W/8-1:0]  res,
    input  logic            word_mode,
    input  logic            mask_format,
    output logic [IW-1:0]   idx,
    output logic [W-1:0]    mask,
    output logic            any_hit
);
    localparam int NB = W / 8;
    localparam int CW = $clog2(NB + 1);

    logic [W-1:0]  byte_mask, word_mask;
    logic [CW-1:0] first;

    for (genvar i = 0; i < NB; i++) begin : g_bm
        assign byte_mask[8*i +: 8] = {8{res[i]}};
    end
    for (genvar j = 0; j < NB / 2; j++) begin : g_wm
        assign word_mask[16*j +: 16] = {16{res[j]}};
    end

    always_comb begin
        first = word_mode ? CW'(NB / 2) : CW'(NB);
        for (int i = NB - 1; i >= 0; i--) begin
            if (res[i]) first = CW'(i);
        end
        any_hit = |res;
        idx     = mask_format ? '0 : IW'(first);
        mask    = mask_format ? (word_mode ? word_mask : byte_mask) : '0;
    end
endmodule

// File: rtl/pstr_cmp_engine.sv
module pstr_cmp_engine
    import pstr_pkg::*;
#(
    parameter int W  = PSTR_W,
    parameter int LW = PSTR_LW,
    parameter int IW = PSTR_IW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [W-1:0]  str_a,
    input  logic [W-1:0]  str_b,
    input  logic [LW-1:0] len_a,
    input  logic [LW-1:0] len_b,
    input  logic          len_implicit,
    input  logic          word_mode,
    input  logic          signed_mode,
    input  logic          mask_format,
    output logic          out_valid,
    output logic [IW-1:0] idx_out,
    output logic [W-1:0]  mask_out,
    output logic          flag_any,
    output logic          flag_a_end,
    output logic          flag_b_end,
    output logic          flag_bit0
);
    localparam int NB = W / 8;

    pstr_state_e   state_q, state_d;
    logic [NB-1:0] va, vb, res;
    logic          a_end, b_end, any_hit;
    logic [IW-1:0] idx_c;
    logic [W-1:0]  mask_c;

    pstr_len_unit #(.W(W), .LW(LW)) u_len_a (
        .str(str_a), .len(len_a), .implicit_len(len_implicit),
        .word_mode(word_mode), .valid(va), .ends_early(a_end));

    pstr_len_unit #(.W(W), .LW(LW)) u_len_b (
        .str(str_b), .len(len_b), .implicit_len(len_implicit),
        .word_mode(word_mode), .valid(vb), .ends_early(b_end));

    pstr_cmp_core #(.W(W)) u_core (
        .str_a(str_a), .str_b(str_b), .valid_a(va), .valid_b(vb),
        .word_mode(word_mode), .signed_mode(signed_mode), .res(res));

    pstr_result_fmt #(.W(W), .IW(IW)) u_fmt (
        .res(res), .word_mode(word_mode), .mask_format(mask_format),
        .idx(idx_c), .mask(mask_c), .any_hit(any_hit));

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = in_valid ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_out    <= '0;
            mask_out   <= '0;
            flag_any   <= 1'b0;
            flag_a_end <= 1'b0;
            flag_b_end <= 1'b0;
            flag_bit0  <= 1'b0;
        end else if (in_valid) begin
            idx_out    <= idx_c;
            mask_out   <= mask_c;
            flag_any   <= any_hit;
            flag_a_end <= a_end;
            flag_b_end <= b_end;
            flag_bit0  <= res[0];
        end
    end

    assign out_valid = (state_q == ST_DONE);

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R1
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R1
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(idx_out) && $stable(mask_out) && $stable(flag_any)));
    // R7
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_out <= IW'(NB));
    // R8
    fmt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_out == '0) || (idx_out == '0));
    // R9
    bit0_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_bit0 |-> flag_any);
    // R9
    mask_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_format) |=> (flag_any == (mask_out != '0)));
endmodule

// File: tb/pstr_cmp_engine_tb.sv
module pstr_cmp_engine_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] str_a = '0, str_b = '0;
    logic [31:0]  len_a = '0, len_b = '0;
    logic         len_implicit = 1'b0, word_mode = 1'b0, signed_mode = 1'b0, mask_format = 1'b0;
    logic         out_valid;
    logic [31:0]  idx_out;
    logic [127:0] mask_out;
    logic         flag_any, flag_a_end, flag_b_end, flag_bit0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pstr_cmp_engine dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .str_a(str_a), .str_b(str_b),
        .len_a(len_a), .len_b(len_b), .len_implicit(len_implicit), .word_mode(word_mode),
        .signed_mode(signed_mode), .mask_format(mask_format), .out_valid(out_valid),
        .idx_out(idx_out), .mask_out(mask_out), .flag_any(flag_any),
        .flag_a_end(flag_a_end), .flag_b_end(flag_b_end), .flag_bit0(flag_bit0));

    function automatic int elem(input logic [127:0] s, input int i, input bit w);
        return w ? int'(s[16*i +: 16]) : int'(s[8*i +: 8]);
    endfunction

    function automatic int eff_len(input logic [127:0] s, input logic [31:0] l, input bit imp, input bit w);
        int cnt = w ? 8 : 16;
        longint m;
        if (imp) begin
            for (int i = 0; i < cnt; i++) if (elem(s, i, w) == 0) return i;
            return cnt;
        end
        m = longint'($signed(l));
        if (m < 0) m = -m;
        return (m > cnt) ? cnt : int'(m);
    endfunction

    task automatic ref_model(input logic [127:0] a, b, input logic [31:0] la, lb,
                             input bit imp, w, mf,
                             output logic [31:0] e_idx, output logic [127:0] e_mask,
                             output logic [3:0] e_flg);
        int cnt = w ? 8 : 16;
        int na = eff_len(a, la, imp, w);
        int nb = eff_len(b, lb, imp, w);
        logic [15:0] r = '0;
        int first = cnt;
        for (int i = 0; i < cnt; i++) begin
            bit va = i < na;
            bit vb = i < nb;
            r[i] = (va && vb && elem(a, i, w) == elem(b, i, w)) || (!va && !vb);
        end
        for (int i = cnt - 1; i >= 0; i--) if (r[i]) first = i;
        e_mask = '0;
        for (int i = 0; i < cnt; i++) begin
            if (r[i]) begin
                if (w) e_mask[16*i +: 16] = 16'hFFFF;
                else   e_mask[8*i +: 8]   = 8'hFF;
            end
        end
        if (!mf) e_mask = '0;
        e_idx = mf ? 32'd0 : 32'(first);
        e_flg = {r != 16'h0, na < cnt, nb < cnt, r[0]};
    endtask

    task automatic chk(input string req, input string what, input logic [127:0] act, exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [127:0] a, b, input logic [31:0] la, lb,
                       input bit imp, w, sg, mf, input string tag);
        logic [31:0]  e_idx;
        logic [127:0] e_mask;
        logic [3:0]   e_flg;
        ref_model(a, b, la, lb, imp, w, mf, e_idx, e_mask, e_flg);
        @(negedge clk);
        str_a = a; str_b = b; len_a = la; len_b = lb;
        len_implicit = imp; word_mode = w; signed_mode = sg; mask_format = mf;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        str_a = ~a; len_a = 32'd3;
        chk("R1", "out_valid", 128'(out_valid), 128'd1);
        chk(tag, mf ? "mask" : "idx", mf ? mask_out : 128'(idx_out), mf ? e_mask : 128'(e_idx));
        chk("R9", "flags", 128'({flag_any, flag_a_end, flag_b_end, flag_bit0}), 128'(e_flg));
        @(negedge clk);
        chk("R1", "hold", {out_valid, idx_out, mask_out[94:0]},
            {1'b0, mf ? 32'd0 : e_idx, e_mask[94:0]});
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [127:0] a, b, base;
        void'($urandom(32'd1234));
        base = 128'h3F3E_3D3C_3B3A_3938_3736_3534_3332_3130;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11", "reset", {out_valid, flag_any, flag_a_end, flag_b_end, flag_bit0, idx_out, mask_out[90:0]}, '0);
        rst_n = 1'b1;

        // R2: differ at 0..5, both length 4 -> idx 4; one long -> 16
        a = base; b = base ^ 128'h00_FFFF_FFFF_FFFF;
        run(a, b, 32'd4, 32'd4, 0, 0, 0, 0, "R2");
        run(a, b, 32'd100, 32'd4, 0, 0, 0, 0, "R2");
        // R2: zero bytes are ordinary data in explicit mode
        a[23:16] = 8'h0; b = a;
        run(a, b, 32'd16, 32'd16, 0, 0, 0, 0, "R2");
        // R3 negative lengths
        a = base; b = base ^ 128'h00_FFFF_FFFF_FFFF;
        run(a, b, -32'sd4, -32'sd4, 0, 0, 0, 0, "R3");
        run(a, b, 32'h8000_0000, -32'sd32, 0, 0, 0, 1, "R3");
        // R4 implicit: zero at element 2 in both, differ at 0,1
        a = base; a[23:16] = 8'h0; b = a ^ 128'h00FF_FF;
        run(a, b, 32'd1, 32'd1, 1, 0, 0, 0, "R4");
        run(a, b, 32'd1, 32'd1, 1, 0, 0, 1, "R4");
        // R6 exactly one valid element
        a = base; b = base; b[39:32] = 8'h0;
        run(a, b, 32'd0, 32'd0, 1, 0, 0, 1, "R6");
        // R5 word mode
        a = base; b = base ^ 128'h0000_0000_0000_0000_0000_0000_0001_0001;
        run(a, b, 32'd8, 32'd8, 0, 1, 0, 0, "R5");
        run(a, b, 32'd3, 32'd8, 0, 1, 0, 1, "R5");
        a[47:32] = 16'h0; b = a;
        run(a, b, 32'd0, 32'd0, 1, 1, 0, 1, "R5");
        // R7 no true element
        a = base; b = ~base;
        run(a, b, 32'd16, 32'd16, 0, 0, 0, 0, "R7");
        run(a, b, 32'd8, 32'd8, 0, 1, 0, 0, "R7");
        // R8 mask mode
        a = base; b = base ^ 128'hFF00_0000_0000_00FF_0000;
        run(a, b, 32'd16, 32'd16, 0, 0, 0, 1, "R8");
        // R10 signedness has no effect
        a = 128'h80FF_7F01_8000_FFFF; b = a;
        run(a, b, 32'd7, 32'd9, 0, 0, 1, 1, "R10");
        run(a, b, 32'd7, 32'd9, 0, 1, 1, 0, "R10");

        for (int n = 0; n < 400; n++) begin
            int p = $urandom_range(0, 3);
            a = {$urandom, $urandom, $urandom, $urandom};
            case (p)
                0: b = a;
                1: b = {$urandom, $urandom, $urandom, $urandom};
                default: begin
                    b = a;
                    b[8*$urandom_range(0, 15) +: 8] ^= 8'h5A;
                end
            endcase
            if ($urandom_range(0, 1) == 1) begin
                int k = $urandom_range(0, 15);
                a[8*k +: 8] = 8'h0;
                if ($urandom_range(0, 1) == 1) b[8*k +: 8] = 8'h0;
                if ($urandom_range(0, 1) == 1) b[8*$urandom_range(0, 15) +: 8] = 8'h0;
            end
            run(a, b,
                ($urandom_range(0, 9) == 0) ? $urandom : 32'($urandom_range(0, 40)) - 32'd20,
                ($urandom_range(0, 9) == 0) ? $urandom : 32'($urandom_range(0, 40)) - 32'd20,
                1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                "R7");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule